// File: doc/BRIEF.md
# Register-Window Bus Bridge

This block gives a 64-bit host a path onto a 32-bit, byte-addressed internal bus through four 64-bit registers. The host first places up to four bytes of write data in the data register. It then writes the control register with the direction, the byte count and the target address. That control write launches one transaction on a request/acknowledge master port.

When the internal bus acknowledges, the outcome lands in a status word that clears when it is read. A completed read places its four bytes in that word with the byte from the lowest address most significant. A read that the bus flags as an error still reports completion, but with all-ones data. A write reports completion only.

While a transaction is outstanding, the status word reads as zero and further control writes are discarded. A host polls status until the done flag appears.

Top module: `regwin_bridge`

## Requirements
- R1: The register index is host_addr[4:3]: 0 selects control, 1 reset, 2 status and 3 data. Reads of control and reset return zero. Writes to status and reset leave the status word and the data register unchanged.
- R2: An accepted control write raises bus_req in the following cycle with these fields: bus_addr equal to bits 31:0 of the write, bus_size equal to bits 59:56, and bus_we low when bit 48 is set (a read) or high when bit 48 is clear (a write).
- R3: When the byte count in bits 59:56 exceeds 8, the control write is dropped. No request is raised and the status word keeps its previous value.
- R4: bus_req stays high with bus_addr, bus_size, bus_we and bus_wdata unchanged until the cycle in which bus_ack is seen. It falls in the cycle after that.
- R5: A read acknowledged with bus_err low loads status with bit 11 set and the four returned bytes in bits 57:26. The byte on bus_rdata[7:0] (offset 0) goes to bits 57:50 and the byte on bus_rdata[31:24] goes to bits 33:26. Every other bit is zero.
- R6: A read acknowledged with bus_err high loads status with bit 11 set and ones in bits 57:26.
- R7: A write presents the data register on bus_wdata with the register's bits 31:24 on byte lane 0 (bus_wdata[7:0]) and bits 7:0 on lane 3. On the acknowledge, status becomes exactly 0x800 whatever bus_err shows.
- R8: A status read returns the current status word and clears it to zero, unless an acknowledge loads a new value in that same cycle.
- R9: A data register write keeps bits 63:32 of the host data. A data read returns the stored 32 bits in bits 63:32 and zeros in bits 31:0.
- R10: While a transaction is outstanding, status reads return zero and control writes are ignored.
- R11: After reset, status and data read as zero and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | HOST_AW | Host byte address; bits 4:3 select the register |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Read data, valid in the cycle of a read strobe |
| bus_req | output | 1 | Internal bus request, held until acknowledged |
| bus_we | output | 1 | 1 for a write transaction |
| bus_addr | output | BUS_AW | Internal bus byte address |
| bus_size | output | 4 | Byte count of the transaction |
| bus_wdata | output | 32 | Write data, byte lane 0 in bits 7:0 |
| bus_ack | input | 1 | One-cycle completion from the internal bus |
| bus_err | input | 1 | Error flag, valid with bus_ack |
| bus_rdata | input | 32 | Read data, valid with bus_ack, byte lane 0 in bits 7:0 |

## Verification
The properties assume that bus_ack is a single-cycle pulse that arrives only while bus_req is high, and that bus_err and bus_rdata are meaningful only with it. They also assume that the host issues at most one access per cycle, each lasting one cycle. The bench keeps to these rules by driving the internal bus from one responder task, which waits a chosen latency after seeing the request and then pulses the acknowledge once. The host tasks drop host_valid after every clock edge. The byte-count sweep covers all sixteen encodings, including the dropped ones, and the latency and error choices vary with each step.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int WIN_W        = 64;
  localparam int LANE_BYTES   = 4;
  localparam int LANE_W       = LANE_BYTES * 8;
  localparam int CMD_RD_BIT   = 48;
  localparam int CMD_CNT_LO   = 56;
  localparam int CMD_CNT_W    = 4;
  localparam int STS_DONE_BIT = 11;
  localparam int STS_DATA_LO  = 26;
  localparam int CNT_LIMIT    = 8;

  typedef enum logic [1:0] {
    WIN_CMD  = 2'd0,
    WIN_KICK = 2'd1,
    WIN_STS  = 2'd2,
    WIN_BUF  = 2'd3
  } win_sel_e;

  typedef struct packed {
    logic                 rd;
    logic [CMD_CNT_W-1:0] cnt;
    logic [31:0]          addr;
  } xfer_cmd_t;

  function automatic xfer_cmd_t split_cmd(input logic [WIN_W-1:0] w);
    xfer_cmd_t c;
    c.rd   = w[CMD_RD_BIT];
    c.cnt  = w[CMD_CNT_LO +: CMD_CNT_W];
    c.addr = w[31:0];
    return c;
  endfunction

  // Reverses byte order: lane 0 <-> most significant byte.
  function automatic logic [LANE_W-1:0] flip_bytes(input logic [LANE_W-1:0] v);
    logic [LANE_W-1:0] r;
    for (int k = 0; k < LANE_BYTES; k++) begin
      r[8*k +: 8] = v[8*(LANE_BYTES-1-k) +: 8];
    end
    return r;
  endfunction

  function automatic logic [WIN_W-1:0] done_word(input logic [LANE_W-1:0] be);
    logic [WIN_W-1:0] s;
    s = '0;
    s[STS_DATA_LO +: LANE_W] = be;
    s[STS_DONE_BIT] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 16
) (
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [HOST_AW-1:0] host_addr,
  output win_sel_e           sel,
  output logic               cmd_wr,
  output logic               buf_wr,
  output logic               sts_rd,
  output logic               any_rd
);
  logic unused_addr;
  assign unused_addr = ^host_addr;

  assign sel    = win_sel_e'(host_addr[4:3]);
  assign cmd_wr = host_valid &  host_write & (sel == WIN_CMD);
  assign buf_wr = host_valid &  host_write & (sel == WIN_BUF);
  assign sts_rd = host_valid & ~host_write & (sel == WIN_STS);
  assign any_rd = host_valid & ~host_write;
endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
  import regwin_pkg::*;
#(
  parameter int BUS_AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  xfer_cmd_t            cmd,
  input  logic [LANE_W-1:0]    buf_q,
  output logic                 busy,
  output logic                 launch_ev,
  output logic                 drop_ev,
  output logic                 done_ev,
  output logic                 done_rd,
  output logic                 done_err,
  output logic [LANE_W-1:0]    done_data,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [BUS_AW-1:0]    bus_addr,
  output logic [CMD_CNT_W-1:0] bus_size,
  output logic [LANE_W-1:0]    bus_wdata,
  input  logic                 bus_ack,
  input  logic                 bus_err,
  input  logic [LANE_W-1:0]    bus_rdata
);
  logic                 busy_q;
  logic                 we_q;
  logic [BUS_AW-1:0]    addr_q;
  logic [CMD_CNT_W-1:0] size_q;
  logic [LANE_W-1:0]    wdata_q;
  logic                 cnt_ok;

  assign cnt_ok    = (cmd.cnt <= CMD_CNT_W'(CNT_LIMIT));
  assign launch_ev = cmd_wr & ~busy_q &  cnt_ok;
  assign drop_ev   = cmd_wr & ~busy_q & ~cnt_ok;
  assign done_ev   = busy_q & bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (launch_ev) begin
      busy_q  <= 1'b1;
      we_q    <= ~cmd.rd;
      addr_q  <= BUS_AW'(cmd.addr);
      size_q  <= cmd.cnt;
      wdata_q <= flip_bytes(buf_q);
    end else if (done_ev) begin
      busy_q  <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign bus_req   = busy_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;
  assign bus_wdata = wdata_q;
  assign done_rd   = ~we_q;
  assign done_err  = bus_err;
  assign done_data = bus_rdata;
endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr,
  input  logic [LANE_W-1:0] buf_in,
  input  logic              sts_rd,
  input  logic              launch_ev,
  input  logic              done_ev,
  input  logic              done_rd,
  input  logic              done_err,
  input  logic [LANE_W-1:0] done_data,
  output logic [LANE_W-1:0] buf_q,
  output logic [WIN_W-1:0]  sts_q
);
  logic [WIN_W-1:0] sts_load;

  always_comb begin
    if (!done_rd)      sts_load = done_word('0) & (WIN_W'(1) << STS_DONE_BIT);
    else if (done_err) sts_load = done_word('1);
    else               sts_load = done_word(flip_bytes(done_data));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      sts_q <= '0;
    end else begin
      if (buf_wr) buf_q <= buf_in;
      if (done_ev)                  sts_q <= sts_load;
      else if (launch_ev || sts_rd) sts_q <= '0;
    end
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int BUS_AW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [3:0]         bus_size,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic               bus_err,
  input  logic [31:0]        bus_rdata
);
  win_sel_e          sel;
  logic              cmd_wr, buf_wr, sts_rd, any_rd;
  logic              busy, launch_ev, drop_ev, done_ev, done_rd, done_err;
  logic [LANE_W-1:0] done_data, buf_q;
  logic [WIN_W-1:0]  sts_q;
  xfer_cmd_t         cmd;

  assign cmd = split_cmd(host_wdata);

  regwin_decode #(.HOST_AW(HOST_AW)) dec_i (
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .sel(sel), .cmd_wr(cmd_wr), .buf_wr(buf_wr), .sts_rd(sts_rd), .any_rd(any_rd)
  );

  regwin_engine #(.BUS_AW(BUS_AW)) eng_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .buf_q(buf_q),
    .busy(busy), .launch_ev(launch_ev), .drop_ev(drop_ev), .done_ev(done_ev),
    .done_rd(done_rd), .done_err(done_err), .done_data(done_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  regwin_regs regs_i (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_in(host_wdata[63:32]),
    .sts_rd(sts_rd), .launch_ev(launch_ev), .done_ev(done_ev), .done_rd(done_rd),
    .done_err(done_err), .done_data(done_data), .buf_q(buf_q), .sts_q(sts_q)
  );

  always_comb begin
    host_rdata = '0;
    if (any_rd) begin
      case (sel)
        WIN_STS: host_rdata = busy ? '0 : sts_q;
        WIN_BUF: host_rdata = {buf_q, 32'h0};
        default: host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker #(
  parameter int HOST_AW = 16,
  parameter int BUS_AW  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_write,
  input logic [HOST_AW-1:0] host_addr,
  input logic [63:0]        host_wdata,
  input logic [63:0]        host_rdata,
  input logic               bus_req,
  input logic               bus_we,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [3:0]         bus_size,
  input logic [31:0]        bus_wdata,
  input logic               bus_ack,
  input logic               bus_err,
  input logic               busy,
  input logic               drop_ev,
  input logic [63:0]        sts_q
);
  logic ctl_w, sts_r;
  assign ctl_w = host_valid & host_write & (host_addr[4:3] == 2'd0);
  assign sts_r = host_valid & ~host_write & (host_addr[4:3] == 2'd2);

  assert_ctl_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write && host_addr[4:3] == 2'd0) |-> host_rdata == 64'h0);

  assert_launch_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !bus_req && host_wdata[59:56] <= 4'd8) |=>
      (bus_req && bus_addr == BUS_AW'($past(host_wdata[31:0])) &&
       bus_size == $past(host_wdata[59:56]) && bus_we == !$past(host_wdata[48])));

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (!bus_req && $stable(sts_q)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size) && $stable(bus_wdata)));

  assert_rd_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we && bus_err) |=> (sts_q == 64'h03FF_FFFF_FC00_0800));

  assert_wr_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we) |=> (sts_q == 64'h800));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_r && !(bus_req && bus_ack)) |=> (sts_q == 64'h0));

  assert_pending_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sts_r) |-> host_rdata == 64'h0);
endmodule

bind regwin_bridge regwin_checker #(.HOST_AW(HOST_AW), .BUS_AW(BUS_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .busy(busy),
  .drop_ev(drop_ev), .sts_q(sts_q)
);

// File: tb/regwin_bridge_tb_top.sv
module regwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [15:0] host_addr = '0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_size;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  regwin_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = 16'(idx << 3); host_wdata = d;
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic host_rd(input int idx, output logic [63:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = 16'(idx << 3);
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_valid = 1'b0;
  endtask

  // Waits lat cycles with the request up, then pulses one acknowledge.
  task automatic serve(input int lat, input logic err, input logic [31:0] rd);
    for (int i = 0; i < lat; i++) @(negedge clk);
    @(negedge clk);
    bus_ack = 1'b1; bus_err = err; bus_rdata = rd;
    @(posedge clk); #1;
    bus_ack = 1'b0; bus_err = 1'b0;
  endtask

  function automatic logic [63:0] cmd_word(input logic rd, input logic [3:0] n, input logic [31:0] a);
    return (64'(rd) << 48) | (64'(n) << 56) | 64'(a);
  endfunction

  function automatic logic [63:0] exp_read(input logic [31:0] lanes, input logic err);
    logic [63:0] v;
    v = 64'h800;
    for (int k = 0; k < 4; k++) begin
      if (err) v = v | (64'hFF << (26 + 8 * (3 - k)));
      else     v = v | (64'((lanes >> (8 * k)) & 32'hFF) << (26 + 8 * (3 - k)));
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_lanes(input logic [31:0] dreg);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) v = v | (((dreg >> (8 * (3 - k))) & 32'hFF) << (8 * k));
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] a, rd;
    logic        er;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    check("R11 req", 64'(bus_req), 64'h0);
    host_rd(2, v); check("R11 status", v, 64'h0);
    host_rd(3, v); check("R11 data", v, 64'h0);

    // R9 data register
    host_wr(3, 64'hDEAD_BEEF_1234_5678);
    host_rd(3, v); check("R9 data", v, 64'hDEAD_BEEF_0000_0000);
    host_wr(3, 64'h0102_0304_FFFF_FFFF);
    host_rd(3, v); check("R9 data2", v, 64'h0102_0304_0000_0000);

    // R1 control / reset read zero
    host_rd(0, v); check("R1 ctl read", v, 64'h0);
    host_rd(1, v); check("R1 rst read", v, 64'h0);

    // Sweep all byte counts for reads
    for (int n = 0; n < 16; n++) begin
      a  = 32'h1000_0000 + 32'(n) * 32'h0000_1111;
      rd = 32'hA0B1_C2D3 ^ (32'(n) * 32'h0101_0101);
      er = (n % 3 == 2);
      if (n <= 8) begin
        host_wr(0, cmd_word(1'b1, 4'(n), a));
        check("R2 req", 64'(bus_req), 64'h1);
        check("R2 addr", 64'(bus_addr), 64'(a));
        check("R2 size", 64'(bus_size), 64'(n));
        check("R2 we", 64'(bus_we), 64'h0);
        serve(n % 4, er, rd);
        check("R4 req falls", 64'(bus_req), 64'h0);
        host_rd(2, v);
        check(er ? "R6 fail status" : "R5 read status", v, exp_read(rd, er));
        host_rd(2, v); check("R8 cleared", v, 64'h0);
      end else begin
        // leave a status value pending, then issue an oversized command
        host_wr(0, cmd_word(1'b1, 4'd4, a));
        serve(0, 1'b0, rd);
        host_wr(0, cmd_word(1'b1, 4'(n), a ^ 32'hFFFF));
        check("R3 no req", 64'(bus_req), 64'h0);
        @(negedge clk);
        check("R3 no req later", 64'(bus_req), 64'h0);
        host_rd(2, v); check("R3 status kept", v, exp_read(rd, 1'b0));
      end
    end

    // R7 writes, with and without bus error
    for (int j = 0; j < 4; j++) begin
      logic [31:0] dv;
      dv = 32'h11223344 + 32'(j) * 32'h1357_9BDF;
      host_wr(3, {dv, 32'h0});
      host_wr(0, cmd_word(1'b0, 4'd4, 32'h2000_0000 + 32'(j * 4)));
      check("R2 we write", 64'(bus_we), 64'h1);
      check("R7 wdata", 64'(bus_wdata), 64'(exp_lanes(dv)));
      serve(j, j[0], 32'hFFFF_0000);
      host_rd(2, v); check("R7 status", v, 64'h800);
    end

    // R10 / R4 pending behaviour
    host_wr(0, cmd_word(1'b1, 4'd4, 32'hCAFE_0000));
    host_rd(2, v); check("R10 pending status", v, 64'h0);
    host_wr(0, cmd_word(1'b0, 4'd2, 32'h0BAD_0000));
    check("R10 addr kept", 64'(bus_addr), 64'h0000_0000_CAFE_0000);
    check("R4 we kept", 64'(bus_we), 64'h0);
    check("R4 size kept", 64'(bus_size), 64'h4);
    serve(2, 1'b0, 32'h4433_2211);
    check("R10 second ignored", 64'(bus_req), 64'h0);
    host_rd(2, v); check("R5 after pending", v, exp_read(32'h4433_2211, 1'b0));

    // R1 writes to status and reset have no effect
    host_wr(3, 64'hAABB_CCDD_0000_0000);
    host_wr(0, cmd_word(1'b1, 4'd1, 32'h3000_0000));
    serve(1, 1'b0, 32'h0000_0055);
    host_wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
    host_wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 no req", 64'(bus_req), 64'h0);
    host_rd(2, v); check("R1 status unchanged", v, exp_read(32'h0000_0055, 1'b0));
    host_rd(3, v); check("R1 data unchanged", v, 64'hAABB_CCDD_0000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule